// File: doc/BRIEF.md
# DMA Word Transfer Cycle Sequencer

This block runs the bus cycle for a single DMA word once a channel has been granted. It starts from an idle state and samples a grant and a channel number. It then drives an address-valid window, read and write command strobes and a terminal-count flag. In the release clock it drives a one-hot update request with the stepped address for the channel register, together with a done pulse. Arbitration, register decode and the address and count registers themselves sit outside the block. The block reads their current values through flat input vectors.

A cycle can run at normal length (four clocks) or compressed (three clocks). In compressed mode the commands and terminal count start together with the address. In memory-to-memory mode the granted channel number is ignored. The block runs a read cycle on channel 0 and then a write cycle on channel 1, and channel 0's address can be held still. A global disable keeps the sequencer from starting new cycles.

Top module: `dma_xfer_sequencer`

## Requirements
- R1: While reset is held and while idle, every output (addr_valid, bus_addr, rd_cmd, wr_cmd, tc, upd_en, upd_addr, done) is zero.
- R2: With compression off, a grant sampled at clock edge k gives addr_valid in cycles k+1..k+3, command strobes in cycles k+2..k+3, and a release cycle k+4 with addr_valid and the strobes low, so the cycle lasts exactly 4 clocks.
- R3: With compression on, addr_valid and the command strobes are both high in cycles k+1..k+2, and release is cycle k+3, so the cycle lasts exactly 3 clocks.
- R4: In a single-channel cycle, rd_cmd and wr_cmd assert together, and bus_addr carries the granted channel's current address in every non-idle cycle.
- R5: With mem2mem set, the granted channel number is ignored. A read cycle on channel 0 (rd_cmd only) is followed at once by a write cycle on channel 1 (wr_cmd only). done asserts only at the write's release.
- R6: With hold_src set, channel 0's release produces no address update: upd_en bit 0 stays low and upd_addr stays zero.
- R7: In each release cycle not covered by R6, upd_en is one-hot on the active channel. upd_addr is that channel's address minus one if its dir_down bit is 1, or plus one if it is 0, wrapping modulo 2^ADDR_W.
- R8: tc is high exactly while the command strobes are high, provided the channel's count is zero. In memory-to-memory mode only channel 1's count during the write cycle counts.
- R9: While cfg_disable is 1, a grant in the idle state starts no cycle.
- R10: done is a single-clock pulse in the release cycle of the final cycle. With grant held high, a new cycle starts one idle clock after each release.
- R11: Grant, channel number and configuration are sampled only in the idle state. Changing them during a cycle does not alter that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| grant | input | 1 | A channel has been granted a word transfer |
| grant_ch | input | CH_W | Granted channel number |
| cfg_compress | input | 1 | 1 selects the 3-clock cycle |
| cfg_disable | input | 1 | 1 blocks new cycles from starting |
| cfg_mem2mem | input | 1 | 1 selects channel 0 to channel 1 copying |
| cfg_hold_src | input | 1 | 1 freezes channel 0's address |
| dir_down | input | NUM_CH | Per-channel step direction, 1 = decrement |
| cur_addr | input | NUM_CH*ADDR_W | Current address of every channel, channel i at bits [i*ADDR_W +: ADDR_W] |
| cur_count | input | NUM_CH*CNT_W | Remaining count of every channel, channel i at bits [i*CNT_W +: CNT_W] |
| addr_valid | output | 1 | Address phase active |
| bus_addr | output | ADDR_W | Address of the active channel |
| rd_cmd | output | 1 | Read command strobe |
| wr_cmd | output | 1 | Write command strobe |
| tc | output | 1 | Terminal count of the final word |
| upd_en | output | NUM_CH | One-hot address-register update request |
| upd_addr | output | ADDR_W | Stepped address to load |
| done | output | 1 | Cycle complete pulse |

## Verification
Every result is due a fixed number of clocks after the edge that samples the grant. The address phase begins one clock later. The strobes and tc follow one clock after that in normal mode, or at the same time in compressed mode. The update request and done land in the last clock: the fourth for normal timing, the third for compressed. In memory-to-memory mode the write cycle follows the read release with no gap. When the bench sees an accepted grant, its model queues one expected output word for each of those clocks. It drives inputs on the falling edge and compares every output on the next falling edge, so each value is checked in the exact clock where it is due and nowhere else. An empty queue means all outputs must be zero.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE = 3'd0,
      SQ_ADDR = 3'd1,
      SQ_CMD  = 3'd2,
      SQ_HOLD = 3'd3,
      SQ_REL  = 3'd4
   } seq_state_e;

endpackage

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
   import dma_seq_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int CH_W   = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            grant,
   input  logic [CH_W-1:0] grant_ch,
   input  logic            cfg_compress,
   input  logic            cfg_disable,
   input  logic            cfg_mem2mem,
   input  logic            cfg_hold_src,
   output logic            busy,
   output logic            ph_av,
   output logic            ph_cmd,
   output logic            ph_rel,
   output logic            ph_last,
   output logic            rd_en,
   output logic            wr_en,
   output logic            hold_act,
   output logic [CH_W-1:0] act_ch
);

   localparam logic [CH_W-1:0] SRC_CH = '0;
   localparam logic [CH_W-1:0] DST_CH = CH_W'(1);

   initial begin
      assert (NUM_CH >= 2 && CH_W >= 1 && (1 << CH_W) >= NUM_CH)
         else $error("dma_seq_ctrl: channel count and select width disagree");
   end

   seq_state_e      st;
   logic            comp_q;
   logic            m2m_q;
   logic            hold_q;
   logic            second_q;
   logic [CH_W-1:0] ch_q;
   logic            accept;

   assign accept = (st == SQ_IDLE) && grant && !cfg_disable;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= SQ_IDLE;
         comp_q   <= 1'b0;
         m2m_q    <= 1'b0;
         hold_q   <= 1'b0;
         second_q <= 1'b0;
         ch_q     <= '0;
      end else begin
         case (st)
            SQ_IDLE: begin
               if (accept) begin
                  comp_q   <= cfg_compress;
                  m2m_q    <= cfg_mem2mem;
                  hold_q   <= cfg_hold_src;
                  second_q <= 1'b0;
                  ch_q     <= cfg_mem2mem ? SRC_CH : grant_ch;
                  st       <= cfg_compress ? SQ_CMD : SQ_ADDR;
               end
            end
            SQ_ADDR: st <= SQ_CMD;
            SQ_CMD:  st <= SQ_HOLD;
            SQ_HOLD: st <= SQ_REL;
            SQ_REL: begin
               if (m2m_q && !second_q) begin
                  second_q <= 1'b1;
                  ch_q     <= DST_CH;
                  st       <= comp_q ? SQ_CMD : SQ_ADDR;
               end else begin
                  st <= SQ_IDLE;
               end
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

   assign busy     = (st != SQ_IDLE);
   assign ph_av    = (st == SQ_ADDR) || (st == SQ_CMD) || (st == SQ_HOLD);
   assign ph_cmd   = (st == SQ_CMD) || (st == SQ_HOLD);
   assign ph_rel   = (st == SQ_REL);
   assign ph_last  = !m2m_q || second_q;
   assign rd_en    = !m2m_q || !second_q;
   assign wr_en    = !m2m_q || second_q;
   assign hold_act = hold_q;
   assign act_ch   = ch_q;

   // R9: a disabled controller stays idle
   p_idle_when_disabled_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (st == SQ_IDLE && cfg_disable) |=> (st == SQ_IDLE));

   // R5: the second half of a copy always addresses channel 1
   p_copy_dest_ch_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (m2m_q && second_q && st != SQ_IDLE) |-> (ch_q == DST_CH));

   // R2: the command window is never a single clock
   p_cmd_two_clocks_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ph_cmd) |=> ph_cmd);

endmodule

// File: rtl/dma_seq_chan_mux.sv
module dma_seq_chan_mux #(
   parameter int NUM_CH    = 4,
   parameter int ADDR_W    = 16,
   parameter int CNT_W     = 16,
   parameter int CH_W      = 2,
   parameter bit SEL_ANDOR = 1'b1
) (
   input  logic [CH_W-1:0]          act_ch,
   input  logic [NUM_CH*ADDR_W-1:0] addr_all,
   input  logic [NUM_CH*CNT_W-1:0]  cnt_all,
   output logic [ADDR_W-1:0]        sel_addr,
   output logic                     cnt_zero
);

   initial begin
      assert (ADDR_W >= 2 && CNT_W >= 1)
         else $error("dma_seq_chan_mux: address or count width too small");
   end

   generate
      if (SEL_ANDOR) begin : g_andor
         logic [NUM_CH-1:0][ADDR_W-1:0] masked;
         logic [NUM_CH-1:0]             zero_hit;
         logic [ADDR_W-1:0]             acc;

         for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            assign masked[i]   = (act_ch == CH_W'(i)) ? addr_all[i*ADDR_W +: ADDR_W] : '0;
            assign zero_hit[i] = (act_ch == CH_W'(i)) && (cnt_all[i*CNT_W +: CNT_W] == '0);
         end

         always_comb begin
            acc = '0;
            for (int k = 0; k < NUM_CH; k++) acc = acc | masked[k];
         end

         assign sel_addr = acc;
         assign cnt_zero = |zero_hit;
      end else begin : g_index
         assign sel_addr = addr_all[act_ch*ADDR_W +: ADDR_W];
         assign cnt_zero = (cnt_all[act_ch*CNT_W +: CNT_W] == '0);
      end
   endgenerate

endmodule

// File: rtl/dma_seq_stepper.sv
module dma_seq_stepper #(
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 16,
   parameter int CH_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ph_rel,
   input  logic              hold_act,
   input  logic [CH_W-1:0]   act_ch,
   input  logic [ADDR_W-1:0] sel_addr,
   input  logic [NUM_CH-1:0] dir_down,
   output logic [NUM_CH-1:0] upd_en,
   output logic [ADDR_W-1:0] upd_addr
);

   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

   logic              dir_sel;
   logic              freeze;
   logic              upd_go;
   logic [ADDR_W-1:0] stepped;

   assign dir_sel = dir_down[act_ch];
   assign stepped = dir_sel ? (sel_addr - ONE) : (sel_addr + ONE);
   assign freeze  = hold_act && (act_ch == '0);
   assign upd_go  = ph_rel && !freeze;

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_upd
         assign upd_en[i] = upd_go && (act_ch == CH_W'(i));
      end
   endgenerate

   assign upd_addr = upd_go ? stepped : '0;

   // R7: never more than one address register is written
   p_upd_onehot_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(upd_en));

   // R6: a held source address is never rewritten
   p_hold_src_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (hold_act && act_ch == '0) |-> (upd_en == '0));

endmodule

// File: rtl/dma_xfer_sequencer.sv
module dma_xfer_sequencer #(
   parameter int NUM_CH    = 4,
   parameter int ADDR_W    = 16,
   parameter int CNT_W     = 16,
   parameter bit SEL_ANDOR = 1'b1,
   localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     grant,
   input  logic [CH_W-1:0]          grant_ch,
   input  logic                     cfg_compress,
   input  logic                     cfg_disable,
   input  logic                     cfg_mem2mem,
   input  logic                     cfg_hold_src,
   input  logic [NUM_CH-1:0]        dir_down,
   input  logic [NUM_CH*ADDR_W-1:0] cur_addr,
   input  logic [NUM_CH*CNT_W-1:0]  cur_count,
   output logic                     addr_valid,
   output logic [ADDR_W-1:0]        bus_addr,
   output logic                     rd_cmd,
   output logic                     wr_cmd,
   output logic                     tc,
   output logic [NUM_CH-1:0]        upd_en,
   output logic [ADDR_W-1:0]        upd_addr,
   output logic                     done
);

   logic            busy;
   logic            ph_av;
   logic            ph_cmd;
   logic            ph_rel;
   logic            ph_last;
   logic            rd_en;
   logic            wr_en;
   logic            hold_act;
   logic [CH_W-1:0] act_ch;
   logic [ADDR_W-1:0] sel_addr;
   logic            cnt_zero;

   dma_seq_ctrl #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .grant(grant), .grant_ch(grant_ch),
      .cfg_compress(cfg_compress), .cfg_disable(cfg_disable),
      .cfg_mem2mem(cfg_mem2mem), .cfg_hold_src(cfg_hold_src),
      .busy(busy), .ph_av(ph_av), .ph_cmd(ph_cmd), .ph_rel(ph_rel),
      .ph_last(ph_last), .rd_en(rd_en), .wr_en(wr_en),
      .hold_act(hold_act), .act_ch(act_ch)
   );

   dma_seq_chan_mux #(
      .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
      .CH_W(CH_W), .SEL_ANDOR(SEL_ANDOR)
   ) u_mux (
      .act_ch(act_ch), .addr_all(cur_addr), .cnt_all(cur_count),
      .sel_addr(sel_addr), .cnt_zero(cnt_zero)
   );

   dma_seq_stepper #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CH_W(CH_W)) u_step (
      .clk(clk), .rst_n(rst_n), .ph_rel(ph_rel), .hold_act(hold_act),
      .act_ch(act_ch), .sel_addr(sel_addr), .dir_down(dir_down),
      .upd_en(upd_en), .upd_addr(upd_addr)
   );

   assign addr_valid = ph_av;
   assign bus_addr   = busy ? sel_addr : '0;
   assign rd_cmd     = ph_cmd && rd_en;
   assign wr_cmd     = ph_cmd && wr_en;
   assign tc         = ph_cmd && ph_last && cnt_zero;
   assign done       = ph_rel && ph_last;

   // R2/R3: strobes only inside the address window
   p_cmd_has_addr_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_cmd || wr_cmd) |-> addr_valid);

   // R8: terminal count never outlives the strobes
   p_tc_inside_cmd_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      tc |-> (rd_cmd || wr_cmd));

   // R10: done lasts one clock
   p_done_pulse_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10: done comes right after the strobes drop
   p_done_after_cmd_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!rd_cmd && !wr_cmd && $past(rd_cmd || wr_cmd)));

   // R5: a copy never strobes read and write together
   p_copy_split_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !(rd_en && wr_en)) |-> !(rd_cmd && wr_cmd));

endmodule

// File: tb/tb_dma_xfer_sequencer.sv
module tb_dma_xfer_sequencer;

   localparam int NUM_CH = 4;
   localparam int ADDR_W = 16;
   localparam int CNT_W  = 16;
   localparam int CH_W   = 2;
   localparam int EW     = 1 + ADDR_W + 3 + NUM_CH + ADDR_W + 1;

   logic                     clk = 1'b0;
   logic                     rst_n;
   logic                     grant;
   logic [CH_W-1:0]          grant_ch;
   logic                     cfg_compress, cfg_disable, cfg_mem2mem, cfg_hold_src;
   logic [NUM_CH-1:0]        dir_down;
   logic [NUM_CH*ADDR_W-1:0] cur_addr;
   logic [NUM_CH*CNT_W-1:0]  cur_count;
   logic                     addr_valid, rd_cmd, wr_cmd, tc, done;
   logic [ADDR_W-1:0]        bus_addr, upd_addr;
   logic [NUM_CH-1:0]        upd_en;

   dma_xfer_sequencer #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut (
      .clk(clk), .rst_n(rst_n), .grant(grant), .grant_ch(grant_ch),
      .cfg_compress(cfg_compress), .cfg_disable(cfg_disable),
      .cfg_mem2mem(cfg_mem2mem), .cfg_hold_src(cfg_hold_src),
      .dir_down(dir_down), .cur_addr(cur_addr), .cur_count(cur_count),
      .addr_valid(addr_valid), .bus_addr(bus_addr), .rd_cmd(rd_cmd),
      .wr_cmd(wr_cmd), .tc(tc), .upd_en(upd_en), .upd_addr(upd_addr),
      .done(done)
   );

   always #5 clk = ~clk;

   logic [EW-1:0] exp_q[$];
   string         tag_q[$];
   string         scen_tag = "R1";
   bit            was_idle = 1'b1;
   bit            finished = 1'b0;
   int            total = 0;
   int            bad   = 0;

   function automatic logic [EW-1:0] mk(input logic av, input logic [ADDR_W-1:0] a,
                                        input logic r, input logic w, input logic t,
                                        input logic [NUM_CH-1:0] ue,
                                        input logic [ADDR_W-1:0] ua, input logic d);
      return {av, a, r, w, t, ue, ua, d};
   endfunction

   function automatic logic [ADDR_W-1:0] addr_of(input int ch);
      return cur_addr[ch*ADDR_W +: ADDR_W];
   endfunction

   function automatic logic zero_of(input int ch);
      return cur_count[ch*CNT_W +: CNT_W] == '0;
   endfunction

   // queue one channel cycle of expected outputs
   task automatic push_cycle(input int ch, input bit comp, input bit r, input bit w,
                             input bit tcv, input bit hold, input bit last);
      int n = comp ? 3 : 4;
      logic [ADDR_W-1:0] a = addr_of(ch);
      for (int i = 0; i < n; i++) begin
         bit av  = (i < n - 1);
         bit cmd = comp ? (i < 2) : (i == 1 || i == 2);
         bit rel = (i == n - 1);
         logic [NUM_CH-1:0] ue = '0;
         logic [ADDR_W-1:0] ua = '0;
         if (rel && !(ch == 0 && hold)) begin
            ue = NUM_CH'(1) << ch;
            ua = dir_down[ch] ? a - ADDR_W'(1) : a + ADDR_W'(1);
         end
         exp_q.push_back(mk(av, a, cmd && r, cmd && w, cmd && tcv, ue, ua, rel && last));
         tag_q.push_back(scen_tag);
      end
   endtask

   task automatic model_edge();
      if (was_idle && grant && !cfg_disable) begin
         if (cfg_mem2mem) begin
            push_cycle(0, cfg_compress, 1, 0, 0, cfg_hold_src, 0);
            push_cycle(1, cfg_compress, 0, 1, zero_of(1), cfg_hold_src, 1);
         end else begin
            push_cycle(int'(grant_ch), cfg_compress, 1, 1, zero_of(int'(grant_ch)),
                       cfg_hold_src, 1);
         end
      end
   endtask

   task automatic compare();
      logic [EW-1:0] got, exp;
      string t;
      got = {addr_valid, bus_addr, rd_cmd, wr_cmd, tc, upd_en, upd_addr, done};
      if (exp_q.size() > 0) begin
         exp = exp_q.pop_front();
         t   = tag_q.pop_front();
         was_idle = 1'b0;
      end else begin
         exp = '0;
         t   = scen_tag;
         was_idle = 1'b1;
      end
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s t=%0t got=%h expected=%h", t, $time, got, exp);
      end
   endtask

   task automatic step();
      model_edge();
      @(negedge clk);
      compare();
   endtask

   task automatic drain();
      while (exp_q.size() > 0) step();
      step();
   endtask

   task automatic go();
      grant = 1'b1;
      step();
      grant = 1'b0;
      drain();
   endtask

   task automatic set_ch(input int ch, input logic [ADDR_W-1:0] a,
                         input logic [CNT_W-1:0] c, input bit down);
      cur_addr[ch*ADDR_W +: ADDR_W] = a;
      cur_count[ch*CNT_W +: CNT_W]  = c;
      dir_down[ch] = down;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; grant = 1'b0; grant_ch = '0;
      cfg_compress = 1'b0; cfg_disable = 1'b0; cfg_mem2mem = 1'b0; cfg_hold_src = 1'b0;
      dir_down = '0; cur_addr = '0; cur_count = '0;
      set_ch(0, 16'h4000, 16'd7, 0);
      set_ch(1, 16'h0100, 16'd3, 0);
      set_ch(2, 16'h1234, 16'd5, 0);
      set_ch(3, 16'h8000, 16'd9, 0);

      // R1: outputs quiet in reset and after
      scen_tag = "R1";
      repeat (3) begin @(negedge clk); compare(); end
      rst_n = 1'b1;
      repeat (3) step();

      // R2: normal 4-clock cycle, channel 2 counting up
      scen_tag = "R2"; grant_ch = 2'd2; go();

      // R3: compressed 3-clock cycle on channel 1
      scen_tag = "R3"; cfg_compress = 1'b1; grant_ch = 2'd1; go();
      cfg_compress = 1'b0;

      // R4: single-channel cycle strobes both commands, channel 3
      scen_tag = "R4"; grant_ch = 2'd3; go();

      // R7: decrement with wrap on channel 3
      scen_tag = "R7"; set_ch(3, 16'h0000, 16'd4, 1); grant_ch = 2'd3; go();

      // R8: terminal count on a zero count, normal then compressed
      scen_tag = "R8"; set_ch(2, 16'h2222, 16'd0, 0); grant_ch = 2'd2; go();
      cfg_compress = 1'b1; go(); cfg_compress = 1'b0;

      // R5: copy channel 0 -> channel 1, granted channel ignored
      scen_tag = "R5"; cfg_mem2mem = 1'b1; grant_ch = 2'd3;
      set_ch(1, 16'h9000, 16'd0, 1);
      go();
      cfg_compress = 1'b1; go(); cfg_compress = 1'b0;

      // R6: hold the source address, in a copy and on a plain channel 0 cycle
      scen_tag = "R6"; cfg_hold_src = 1'b1; go();
      cfg_mem2mem = 1'b0; grant_ch = 2'd0; go();
      cfg_hold_src = 1'b0;

      // R9: disabled controller ignores a grant
      scen_tag = "R9"; cfg_disable = 1'b1; grant = 1'b1; grant_ch = 2'd2;
      repeat (6) step();
      grant = 1'b0; cfg_disable = 1'b0; step();

      // R10: grant held high gives back-to-back cycles with one idle clock
      scen_tag = "R10"; grant = 1'b1; grant_ch = 2'd1;
      repeat (14) step();
      grant = 1'b0; drain();

      // R11: inputs changed mid-cycle only affect the next cycle
      scen_tag = "R11"; grant = 1'b1; grant_ch = 2'd2;
      step();
      grant_ch = 2'd3; cfg_compress = 1'b1; cfg_mem2mem = 1'b1;
      repeat (6) step();
      grant = 1'b0; cfg_compress = 1'b0; cfg_mem2mem = 1'b0;
      drain();

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule